// File: doc/BRIEF.md
# Masked PCI Configuration Register File

This block holds a complete 256-byte type-0 configuration space in flip-flops and serves it through a single request port. Each request names a starting byte offset, a byte count of one to four, a direction and a little-endian data word. Data lane `n` carries the byte at offset `start + n`. Exactly one cycle after every request, the block returns a response with read data and an error flag.

Writes to the standard header, which is the first 64 bytes, pass through a fixed per-byte table of writable bits. The high status byte behaves as write-one-to-clear. Writes to bytes above the header are stored exactly as given.

The header holds six base-address dwords and an expansion-ROM dword. Writing the probe pattern to one of these dwords makes it read back as a size mask. The first two pairs of base-address dwords form two 64-bit windows: a register window and an aperture window. Each window drives a decode-enable output. That output follows the command register's memory-enable bit, and it drops whenever the window is being sized. Reset loads a parameterised default image with the command enables, the upper halves of the 64-bit pairs, the unused pair and the ROM dword all cleared.

Top module: `cfgrf_top`

## Requirements
- R1: Each request produces `rsp_valid` exactly one cycle later. Read data lane `n` holds the byte at `start + n` for `n < size`, and every other lane reads as zero. Writes return zero data.
- R2: In bytes 0x00–0x3F, only the bits set in the write table change. The table is: offset 0x04 = 0xFF, offset 0x05 = 0x07, offset 0x06 = 0x00, offset 0x07 = 0xF9, offset 0x0C = 0xFF, offsets 0x10–0x27 = 0xFF, offset 0x30 = 0x01, offset 0x31 = 0xF8, offsets 0x32–0x33 = 0xFF and offset 0x3C = 0xFF. Every other byte in the header is read-only.
- R3: In byte 0x07, a table bit written as 1 clears the stored bit, and a bit written as 0 leaves it unchanged.
- R4: Bytes at offsets 0x40–0xFF store the written value unmasked.
- R5: A 4-byte write to 0x30 with data bits [31:11] all ones zeroes the whole ROM dword. Any other write to 0x30 follows R2.
- R6: A 4-byte all-ones write to 0x10, 0x14, 0x18 or 0x1C stores the complement of (window size − 1). The register window covers 0x10/0x14 and the aperture window covers 0x18/0x1C. The dword at the lower address, which is 8-byte aligned, takes bits [31:0], and the other dword takes bits [63:32].
- R7: A 4-byte all-ones write to 0x20 or 0x24 makes that dword read back as zero.
- R8: A sizing probe of a window drops that window's decode enable. Any other accepted write to a dword of that window sets the enable to the current memory-enable bit (bit 1 of offset 0x04).
- R9: An accepted write starting at 0x04 whose data bit 1 differs from the stored memory-enable bit sets both decode enables to the written bit. A write that leaves bit 1 unchanged leaves both enables unchanged.
- R10: A request is rejected with `rsp_err` and zero data, and changes no state, in any of these cases: size is 0 or above 4; start + size exceeds 256; a write starts at 0x04 with size above 2; a write targets dwords 0x10–0x27 or 0x30 at an offset that is not a multiple of 4.
- R11: After reset, the block holds the parameterised vendor, device, status, revision, class, interrupt pin, register-window low dword and aperture base (low bits 0xC). All other bytes are zero, including the command register. Both decode enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads the default image |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Starting byte offset |
| req_size | input | 3 | Byte count |
| req_wdata | input | 32 | Write data, lane n for offset start + n |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| mmio_decode_en | output | 1 | Register window decode enable |
| aper_decode_en | output | 1 | Aperture window decode enable |

## Verification
The hardest state to reach from the ports is a window enable that disagrees with the memory-enable bit. The only paths there are a sizing probe, which drops the enable while memory decode stays on, and a later plain base-address write, which must restore the enable. The bench therefore turns memory decode on first and probes each window in turn. It checks that only the probed window's enable falls. It then rewrites each dword and checks that the enable returns. Finally it clears memory decode and rewrites a base address to show that the enable stays low.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    localparam int unsigned CFG_BYTES   = 256;
    localparam int unsigned LANES       = 4;
    localparam logic [7:0]  HDR_END     = 8'h40;
    localparam logic [7:0]  OFF_CMD     = 8'h04;
    localparam logic [7:0]  OFF_STAT_HI = 8'h07;
    localparam logic [7:0]  OFF_BAR_LO  = 8'h10;
    localparam logic [7:0]  OFF_BAR_HI  = 8'h24;
    localparam logic [7:0]  OFF_ROM     = 8'h30;
    localparam int unsigned MEM_EN_BIT  = 1;

    typedef enum logic [2:0] {
        ACC_PLAIN,
        ACC_CMD,
        ACC_ROM_PROBE,
        ACC_BAR_PROBE,
        ACC_BAR_WR
    } acc_kind_e;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_MMIO,
        WIN_APER
    } win_e;

    typedef struct packed {
        logic       err;
        acc_kind_e  kind;
        win_e       win;
        logic       upper_half;
        logic [3:0] lane_en;
    } req_dec_t;

    // writable-bit table of the standard header
    function automatic logic [7:0] wr_mask(input logic [7:0] off);
        logic [7:0] m;
        m = 8'h00;
        if (off >= OFF_BAR_LO && off <= OFF_BAR_HI + 8'd3) m = 8'hFF;
        case (off)
            8'h04:        m = 8'hFF;
            8'h05:        m = 8'h07;
            8'h07:        m = 8'hF9;
            8'h0C:        m = 8'hFF;
            8'h30:        m = 8'h01;
            8'h31:        m = 8'hF8;
            8'h32, 8'h33: m = 8'hFF;
            8'h3C:        m = 8'hFF;
            default:      ;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] merge_byte(input logic [7:0] off,
                                              input logic [7:0] old_b,
                                              input logic [7:0] wr_b);
        logic [7:0] m;
        logic [7:0] nb;
        if (off >= HDR_END) return wr_b;
        m  = wr_mask(off);
        nb = wr_b & m;
        if (off == OFF_STAT_HI) nb = (~nb & old_b) & m;
        return (old_b & ~m) | nb;
    endfunction

    function automatic logic [7:0] default_byte(input logic [7:0]  off,
                                                input logic [15:0] vendor,
                                                input logic [15:0] device,
                                                input logic [15:0] status,
                                                input logic [7:0]  rev,
                                                input logic [23:0] class_code,
                                                input logic [31:0] bar0_word,
                                                input logic [31:0] bar2_word,
                                                input logic [7:0]  int_pin);
        logic [4:0] sh;
        sh = {off[1:0], 3'b000};
        case (off)
            8'h00, 8'h01:               return vendor[{off[0], 3'b000} +: 8];
            8'h02, 8'h03:               return device[{off[0], 3'b000} +: 8];
            8'h06, 8'h07:               return status[{off[0], 3'b000} +: 8];
            8'h08:                      return rev;
            8'h09:                      return class_code[7:0];
            8'h0A:                      return class_code[15:8];
            8'h0B:                      return class_code[23:16];
            8'h10, 8'h11, 8'h12, 8'h13: return bar0_word[sh +: 8];
            8'h18, 8'h19, 8'h1A, 8'h1B: return bar2_word[sh +: 8];
            8'h3D:                      return int_pin;
            default:                    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgrf_req_decode.sv
module cfgrf_req_decode
    import cfgrf_pkg::*;
(
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output req_dec_t    dec
);
    logic [8:0] end_off;
    logic [7:0] dw_base;
    logic [3:0] bar_idx;
    logic       size_bad, out_of_range, in_bar, in_rom, misaligned, cmd_wide;
    logic       full_word, all_ones, rom_probe_pat;

    always_comb begin
        end_off       = {1'b0, req_addr} + {6'b0, req_size};
        dw_base       = {req_addr[7:2], 2'b00};
        size_bad      = (req_size == 3'd0) || (req_size > 3'd4);
        out_of_range  = end_off > 9'(CFG_BYTES);
        in_bar        = (dw_base >= OFF_BAR_LO) && (dw_base <= OFF_BAR_HI);
        in_rom        = (dw_base == OFF_ROM);
        misaligned    = (in_bar || in_rom) && (req_addr[1:0] != 2'b00);
        cmd_wide      = (req_addr == OFF_CMD) && (req_size > 3'd2);
        full_word     = (req_size == 3'd4);
        all_ones      = full_word && (&req_wdata);
        rom_probe_pat = full_word && (&req_wdata[31:11]);
        bar_idx       = req_addr[5:2] - 4'd4;

        dec.err        = size_bad || out_of_range ||
                         (req_write && (misaligned || cmd_wide));
        dec.upper_half = req_addr[2];
        for (int l = 0; l < LANES; l++)
            dec.lane_en[l] = (3'(l) < req_size);

        dec.win = WIN_NONE;
        if (in_bar) begin
            if (bar_idx < 4'd2)      dec.win = WIN_MMIO;
            else if (bar_idx < 4'd4) dec.win = WIN_APER;
        end

        if (req_addr == OFF_CMD)  dec.kind = ACC_CMD;
        else if (in_rom)          dec.kind = rom_probe_pat ? ACC_ROM_PROBE : ACC_PLAIN;
        else if (in_bar)          dec.kind = all_ones ? ACC_BAR_PROBE : ACC_BAR_WR;
        else                      dec.kind = ACC_PLAIN;
    end
endmodule

// File: rtl/cfgrf_lane_merge.sv
module cfgrf_lane_merge
    import cfgrf_pkg::*;
#(
    parameter int unsigned NLANES = 4
) (
    input  logic [7:0]          base_addr,
    input  logic [NLANES*8-1:0] old_word,
    input  logic [NLANES*8-1:0] wr_word,
    output logic [NLANES*8-1:0] new_word
);
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [7:0] off;
        assign off = base_addr + 8'(g);
        assign new_word[g*8 +: 8] = merge_byte(off, old_word[g*8 +: 8], wr_word[g*8 +: 8]);
    end
endmodule

// File: rtl/cfgrf_window_ctl.sv
module cfgrf_window_ctl
    import cfgrf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ok,
    input  acc_kind_e kind,
    input  win_e      win,
    input  logic      mem_en_now,
    input  logic      mem_en_wr,
    output logic      mmio_en,
    output logic      aper_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mmio_en <= 1'b0;
            aper_en <= 1'b0;
        end else if (wr_ok) begin
            case (kind)
                ACC_CMD: if (mem_en_wr != mem_en_now) begin
                    mmio_en <= mem_en_wr;
                    aper_en <= mem_en_wr;
                end
                ACC_BAR_PROBE: begin
                    if (win == WIN_MMIO) mmio_en <= 1'b0;
                    if (win == WIN_APER) aper_en <= 1'b0;
                end
                ACC_BAR_WR: begin
                    if (win == WIN_MMIO) mmio_en <= mem_en_now;
                    if (win == WIN_APER) aper_en <= mem_en_now;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
    import cfgrf_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID   = 16'h0A11,
    parameter logic [15:0] STATUS_INIT = 16'hF910,
    parameter logic [7:0]  REVISION    = 8'h01,
    parameter logic [23:0] CLASS_CODE  = 24'h030000,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [31:0] BAR0_INIT   = 32'h0000_0004,
    parameter logic [31:0] APER_BASE   = 32'hC000_0000,
    parameter logic [63:0] MMIO_SIZE   = 64'h0000_0000_0100_0000,
    parameter logic [63:0] APER_SIZE   = 64'h0000_0000_2000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        mmio_decode_en,
    output logic        aper_decode_en
);
    localparam logic [63:0] MMIO_PROBE = ~(MMIO_SIZE - 64'd1);
    localparam logic [63:0] APER_PROBE = ~(APER_SIZE - 64'd1);
    localparam logic [31:0] BAR2_INIT  = APER_BASE | 32'h0000_000C;

    logic [7:0]  cfg_q [CFG_BYTES];
    req_dec_t    dec;
    logic [31:0] old_word, merged_word, probe_word, store_word, rd_word;
    logic        wr_ok;

    cfgrf_req_decode u_dec (
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .dec       (dec)
    );

    always_comb begin
        for (int l = 0; l < LANES; l++)
            old_word[l*8 +: 8] = cfg_q[req_addr + 8'(l)];
    end

    cfgrf_lane_merge #(.NLANES(LANES)) u_merge (
        .base_addr (req_addr),
        .old_word  (old_word),
        .wr_word   (req_wdata),
        .new_word  (merged_word)
    );

    always_comb begin
        case (dec.win)
            WIN_MMIO: probe_word = dec.upper_half ? MMIO_PROBE[63:32] : MMIO_PROBE[31:0];
            WIN_APER: probe_word = dec.upper_half ? APER_PROBE[63:32] : APER_PROBE[31:0];
            default:  probe_word = 32'h0;
        endcase
        case (dec.kind)
            ACC_ROM_PROBE: store_word = 32'h0;
            ACC_BAR_PROBE: store_word = probe_word;
            default:       store_word = merged_word;
        endcase
        for (int l = 0; l < LANES; l++)
            rd_word[l*8 +: 8] = dec.lane_en[l] ? old_word[l*8 +: 8] : 8'h00;
    end

    assign wr_ok = req_valid && req_write && !dec.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++)
                cfg_q[i] <= default_byte(8'(i), VENDOR_ID, DEVICE_ID, STATUS_INIT,
                                         REVISION, CLASS_CODE, BAR0_INIT,
                                         BAR2_INIT, INT_PIN);
        end else if (wr_ok) begin
            for (int l = 0; l < LANES; l++)
                if (dec.lane_en[l])
                    cfg_q[req_addr + 8'(l)] <= store_word[l*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= 32'h0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.err;
            rsp_rdata <= (req_valid && !req_write && !dec.err) ? rd_word : 32'h0;
        end
    end

    cfgrf_window_ctl u_win (
        .clk        (clk),
        .rst        (rst),
        .wr_ok      (wr_ok),
        .kind       (dec.kind),
        .win        (dec.win),
        .mem_en_now (cfg_q[OFF_CMD][MEM_EN_BIT]),
        .mem_en_wr  (req_wdata[MEM_EN_BIT]),
        .mmio_en    (mmio_decode_en),
        .aper_en    (aper_decode_en)
    );
endmodule

// File: rtl/cfgrf_top_chk.sv
module cfgrf_top_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        mmio_decode_en,
    input logic        aper_decode_en
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == 32'h0)); // R10
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_size == 3'd0 || req_size > 3'd4)) |=> rsp_err); // R10
    AST_ERR_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> ($stable(mmio_decode_en) && $stable(aper_decode_en))); // R10
    AST_IDLE_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(mmio_decode_en) && $stable(aper_decode_en))); // R9
endmodule

bind cfgrf_top cfgrf_top_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_size       (req_size),
    .rsp_valid      (rsp_valid),
    .rsp_err        (rsp_err),
    .rsp_rdata      (rsp_rdata),
    .mmio_decode_en (mmio_decode_en),
    .aper_decode_en (aper_decode_en)
);

// File: tb/cfgrf_top_tb.sv
module cfgrf_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = 8'h0;
    logic [2:0]  req_size = 3'd0;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_valid, rsp_err, mmio_decode_en, aper_decode_en;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    logic [31:0] got_data;
    logic        got_err, got_valid;

    always #5 clk = ~clk;

    cfgrf_top u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
        .mmio_decode_en (mmio_decode_en), .aper_decode_en (aper_decode_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] a, input logic [2:0] s,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        got_valid = rsp_valid; got_err = rsp_err; got_data = rsp_rdata;
    endtask

    task automatic rd(input logic [7:0] a, input logic [2:0] s);
        access(1'b0, a, s, 32'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
        access(1'b1, a, s, d);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_state();
        rd(8'h00, 3'd4); check("R11 ids", got_data, 32'h0A11_C0DE);
        rd(8'h04, 3'd4); check("R11 cmd/status", got_data, 32'hF910_0000);
        rd(8'h10, 3'd4); check("R11 bar0", got_data, 32'h0000_0004);
        rd(8'h14, 3'd4); check("R11 bar1", got_data, 32'h0);
        rd(8'h18, 3'd4); check("R11 bar2", got_data, 32'hC000_000C);
        rd(8'h20, 3'd4); check("R11 bar4", got_data, 32'h0);
        rd(8'h30, 3'd4); check("R11 rom", got_data, 32'h0);
        check("R11 enables", {30'h0, mmio_decode_en, aper_decode_en}, 32'h0);
    endtask

    task automatic t_read_lanes();
        rd(8'h00, 3'd2);
        check("R1 valid", {31'h0, got_valid}, 32'h1);
        check("R1 lanes", got_data, 32'h0000_C0DE);
        rd(8'h09, 3'd3); check("R1 class", got_data, 32'h0003_0000);
        wr(8'h40, 3'd1, 32'h0000_00AA); check("R1 write data", got_data, 32'h0);
    endtask

    task automatic t_masks();
        wr(8'h00, 3'd4, 32'hFFFF_FFFF);
        rd(8'h00, 3'd4); check("R2 ro ids", got_data, 32'h0A11_C0DE);
        wr(8'h05, 3'd1, 32'h0000_00FF);
        rd(8'h04, 3'd2); check("R2 cmd hi mask", got_data, 32'h0000_0700);
        wr(8'h05, 3'd1, 32'h0);
        wr(8'h3C, 3'd2, 32'h0000_FFFF);
        rd(8'h3C, 3'd2); check("R2 int line/pin", got_data, 32'h0000_01FF);
    endtask

    task automatic t_rw1c();
        wr(8'h07, 3'd1, 32'h10);
        rd(8'h06, 3'd2); check("R3 clear one", got_data, 32'h0000_E910);
        wr(8'h07, 3'd1, 32'h06);
        rd(8'h06, 3'd2); check("R3 unmasked ignored", got_data, 32'h0000_E910);
        wr(8'h06, 3'd2, 32'hFF00);
        rd(8'h06, 3'd2); check("R3 clear all", got_data, 32'h0000_0010);
    endtask

    task automatic t_raw();
        wr(8'h40, 3'd4, 32'hDEAD_BEEF);
        rd(8'h40, 3'd4); check("R4 raw 0x40", got_data, 32'hDEAD_BEEF);
        wr(8'hFC, 3'd4, 32'h1122_3344);
        rd(8'hFC, 3'd4); check("R4 raw top", got_data, 32'h1122_3344);
    endtask

    task automatic t_cmd();
        wr(8'h04, 3'd2, 32'h0002);
        check("R9 enable on", {30'h0, mmio_decode_en, aper_decode_en}, 32'h3);
        wr(8'h04, 3'd1, 32'h06);
        check("R9 no toggle", {30'h0, mmio_decode_en, aper_decode_en}, 32'h3);
        wr(8'h04, 3'd1, 32'h00);
        check("R9 enable off", {30'h0, mmio_decode_en, aper_decode_en}, 32'h0);
        wr(8'h04, 3'd2, 32'h0002);
    endtask

    task automatic t_bar();
        wr(8'h10, 3'd4, 32'hFFFF_FFFF);
        check("R8 mmio probe drops", {30'h0, mmio_decode_en, aper_decode_en}, 32'h1);
        rd(8'h10, 3'd4); check("R6 mmio low", got_data, 32'hFF00_0000);
        wr(8'h14, 3'd4, 32'hFFFF_FFFF);
        rd(8'h14, 3'd4); check("R6 mmio high", got_data, 32'hFFFF_FFFF);
        wr(8'h18, 3'd4, 32'hFFFF_FFFF);
        check("R8 aper probe drops", {30'h0, mmio_decode_en, aper_decode_en}, 32'h0);
        rd(8'h18, 3'd4); check("R6 aper low", got_data, 32'hE000_0000);
        wr(8'h1C, 3'd4, 32'hFFFF_FFFF);
        rd(8'h1C, 3'd4); check("R6 aper high", got_data, 32'hFFFF_FFFF);
        wr(8'h10, 3'd4, 32'h8000_0004);
        rd(8'h10, 3'd4); check("R6 bar write", got_data, 32'h8000_0004);
        check("R8 mmio restored", {31'h0, mmio_decode_en}, 32'h1);
        wr(8'h1C, 3'd4, 32'h0);
        check("R8 aper restored", {31'h0, aper_decode_en}, 32'h1);
        wr(8'h04, 3'd2, 32'h0);
        wr(8'h10, 3'd4, 32'h9000_0004);
        check("R8 follows mem off", {30'h0, mmio_decode_en, aper_decode_en}, 32'h0);
    endtask

    task automatic t_unimpl();
        wr(8'h20, 3'd4, 32'h1234_5678);
        rd(8'h20, 3'd4); check("R7 plain write", got_data, 32'h1234_5678);
        wr(8'h20, 3'd4, 32'hFFFF_FFFF);
        rd(8'h20, 3'd4); check("R7 probe bar4", got_data, 32'h0);
        wr(8'h24, 3'd4, 32'hFFFF_FFFF);
        rd(8'h24, 3'd4); check("R7 probe bar5", got_data, 32'h0);
    endtask

    task automatic t_rom();
        wr(8'h30, 3'd4, 32'h1234_5678);
        rd(8'h30, 3'd4); check("R5 masked rom", got_data, 32'h1234_5000);
        wr(8'h30, 3'd4, 32'hFFFF_F801);
        rd(8'h30, 3'd4); check("R5 rom probe", got_data, 32'h0);
    endtask

    task automatic t_errors();
        wr(8'h04, 3'd2, 32'h0002);
        rd(8'h00, 3'd5); check("R10 wide read", {31'h0, got_err}, 32'h1);
        check("R10 err data", got_data, 32'h0);
        rd(8'hFE, 3'd4); check("R10 past end", {31'h0, got_err}, 32'h1);
        wr(8'h04, 3'd3, 32'h0);
        check("R10 wide cmd", {31'h0, got_err}, 32'h1);
        check("R10 enables kept", {30'h0, mmio_decode_en, aper_decode_en}, 32'h3);
        rd(8'h04, 3'd1); check("R10 cmd kept", got_data, 32'h02);
        wr(8'h12, 3'd2, 32'hFFFF);
        check("R10 misaligned bar", {31'h0, got_err}, 32'h1);
        rd(8'h10, 3'd4); check("R10 bar kept", got_data, 32'h9000_0004);
        check("R10 good access", {31'h0, got_err}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_read_lanes();
        t_masks();
        t_rw1c();
        t_raw();
        t_cmd();
        t_bar();
        t_unimpl();
        t_rom();
        t_errors();
        do_reset();
        t_reset_state();
        rd(8'h40, 3'd4); check("R11 ext cleared", got_data, 32'h0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule